// File: doc/BRIEF.md
# Saturating Integer Divide Unit

This block is the divide unit of a processor execute stage. A single start pulse hands it a dividend, a divisor and an 8-bit secondary operation code. The code picks signed or unsigned division. The unit then returns a 64-bit word. The quotient sits in the low half and the remainder in the high half, so a register file can write the two halves straight into an even/odd register pair. The unit never traps. Division by zero, and the one signed case that cannot be represented, give fixed saturated values and raise an overflow flag. A sticky copy of that flag collects every overflow until reset.

Ordinary divisions run on a radix-2 restoring datapath that works on operand magnitudes. The controller has three named states. ST_IDLE waits for a start. ST_ITER performs one quotient bit per cycle, 32 times. ST_FIXUP applies the result signs and publishes the result. The transitions are as follows:
- IDLE to ITER on an accepted start with ordinary operands.
- IDLE to IDLE on a saturating case, which publishes its result at once.
- ITER to ITER while bits remain.
- ITER to FIXUP after the last bit.
- FIXUP to IDLE unconditionally.

A start is accepted only in ST_IDLE. That includes the cycle in which `done` is high, so results can be issued back to back.

Top module: `sat_div_unit`

## Requirements
- R1: Opcode 0x20 selects signed division and opcode 0x21 selects unsigned division. A start with any other opcode is rejected: `busy` stays low, no `done` follows, and the result and flags keep their values.
- R2: The result word carries the remainder in bits 63:32 and the quotient in bits 31:0. Unsigned division with a nonzero divisor gives floor(a/b) and a mod b.
- R3: Signed division with a nonzero divisor, other than the case in R5, truncates the quotient toward zero. The remainder takes the sign of the dividend, so that dividend = quotient × divisor + remainder.
- R4: Signed division by zero gives quotient 0x7FFFFFFF when the dividend is zero or positive, and 0x80000000 when it is negative. The remainder is 0 in both cases.
- R5: Signed 0x80000000 divided by 0xFFFFFFFF gives quotient 0x7FFFFFFF and remainder 0.
- R6: Unsigned division by zero gives quotient 0xFFFFFFFF and remainder 0.
- R7: `ovf` is set by the cases in R4, R5 and R6 and cleared by every other completed division. It changes only in a cycle in which `done` is high, as does `result`.
- R8: `ovf_sticky` becomes the OR of its previous value and the new `ovf` each time `done` is high. Only reset clears it.
- R9: `adv_ovf` is cleared by every completed division.
- R10: An ordinary division raises `busy` from the cycle after the start edge and pulses `done` 33 cycles after the start edge, with `busy` low in that cycle. A saturating case pulses `done` in the cycle right after the start and never raises `busy`.
- R11: A start that arrives while `busy` is high is ignored.
- R12: While reset is applied, `busy`, `done`, `result` and all three flags are zero.
- R13: `done` lasts one cycle per accepted division. A start presented in a `done` cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a division with the present operands |
| opcode | input | 8 | Secondary operation code: 0x20 signed, 0x21 unsigned |
| dividend | input | 32 | Dividend operand |
| divisor | input | 32 | Divisor operand |
| busy | output | 1 | An ordinary division is in progress |
| done | output | 1 | One-cycle pulse: result and flags are new |
| result | output | 64 | Remainder in bits 63:32, quotient in bits 31:0 |
| ovf | output | 1 | Overflow flag of the latest division |
| ovf_sticky | output | 1 | Accumulated overflow flag |
| adv_ovf | output | 1 | Advanced-overflow flag, cleared by each division |

## Verification
Two functions can fall in the same cycle: completing one division (`done` high, result and flags written) and accepting the next start. The bench provokes this by waiting until `done` is visible and presenting a new start in that same cycle. It does this first with a saturating case that follows an ordinary division, then with an ordinary division that follows the saturating one. A behavioural model decides every cycle which start is accepted and when each result is due. Each `done`, each `busy` level and the whole result and flag state are compared against it, so a lost start, a merged pulse or a sticky flag that drops shows up as a miscompare.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

    localparam int OPC_W = 8;

    localparam logic [OPC_W-1:0] OPC_DIV_SIGNED   = 8'h20;
    localparam logic [OPC_W-1:0] OPC_DIV_UNSIGNED = 8'h21;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ITER  = 2'd1,
        ST_FIXUP = 2'd2
    } div_state_e;

endpackage

// File: rtl/sdiv_decode.sv
module sdiv_decode
    import sdiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [OPC_W-1:0] opcode,
    input  logic [W-1:0]     op_a,
    input  logic [W-1:0]     op_b,
    output logic             op_ok,
    output logic             special,
    output logic [W-1:0]     sp_quo,
    output logic [W-1:0]     sp_rem,
    output logic [W-1:0]     a_mag,
    output logic [W-1:0]     b_mag,
    output logic             quo_neg,
    output logic             rem_neg
);

    localparam logic [W-1:0] MAX_POS  = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MIN_NEG  = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    logic is_signed;
    logic a_neg;
    logic b_neg;
    logic zero_div;
    logic sig_ovf;

    always_comb begin
        is_signed = (opcode == OPC_DIV_SIGNED);
        op_ok     = is_signed || (opcode == OPC_DIV_UNSIGNED);
        a_neg     = is_signed && op_a[W-1];
        b_neg     = is_signed && op_b[W-1];
        a_mag     = a_neg ? (-op_a) : op_a;
        b_mag     = b_neg ? (-op_b) : op_b;
        zero_div  = (op_b == '0);
        sig_ovf   = is_signed && (op_a == MIN_NEG) && (op_b == ALL_ONES);
        special   = zero_div || sig_ovf;
        sp_rem    = '0;
        if (is_signed) begin
            sp_quo = (zero_div && a_neg) ? MIN_NEG : MAX_POS;
        end else begin
            sp_quo = ALL_ONES;
        end
        quo_neg   = a_neg ^ b_neg;
        rem_neg   = a_neg;
    end

endmodule

// File: rtl/sdiv_ctrl.sv
module sdiv_ctrl
    import sdiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic op_ok,
    input  logic special,
    output logic busy,
    output logic load,
    output logic step,
    output logic fixup,
    output logic sp_fire
);

    localparam int CW = (W > 2) ? $clog2(W) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(W - 1);

    div_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          accept;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        busy    = 1'b0;
        load    = 1'b0;
        step    = 1'b0;
        fixup   = 1'b0;
        sp_fire = 1'b0;
        accept  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                accept = start && op_ok;
                if (accept && special) begin
                    sp_fire = 1'b1;
                end else if (accept) begin
                    load    = 1'b1;
                    cnt_d   = '0;
                    state_d = ST_ITER;
                end
            end
            ST_ITER: begin
                busy = 1'b1;
                step = 1'b1;
                if (cnt_q == CNT_LAST) begin
                    state_d = ST_FIXUP;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_FIXUP: begin
                busy    = 1'b1;
                fixup   = 1'b1;
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/sdiv_core.sv
module sdiv_core #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] a_mag,
    input  logic [W-1:0] b_mag,
    output logic [W-1:0] q_mag,
    output logic [W-1:0] r_mag
);

    logic [W-1:0] quo_q;
    logic [W-1:0] rem_q;
    logic [W-1:0] dvs_q;
    logic [W:0]   partial;
    logic         fits;
    logic [W-1:0] rem_sub;

    always_comb begin
        partial = {rem_q, quo_q[W-1]};
        fits    = (partial >= {1'b0, dvs_q});
        rem_sub = W'(partial - {1'b0, dvs_q});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quo_q <= '0;
            rem_q <= '0;
            dvs_q <= '0;
        end else if (load) begin
            quo_q <= a_mag;
            rem_q <= '0;
            dvs_q <= b_mag;
        end else if (step) begin
            quo_q <= {quo_q[W-2:0], fits};
            rem_q <= fits ? rem_sub : partial[W-1:0];
        end
    end

    assign q_mag = quo_q;
    assign r_mag = rem_q;

endmodule

// File: rtl/sat_div_unit.sv
module sat_div_unit
    import sdiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [OPC_W-1:0] opcode,
    input  logic [W-1:0]     dividend,
    input  logic [W-1:0]     divisor,
    output logic             busy,
    output logic             done,
    output logic [2*W-1:0]   result,
    output logic             ovf,
    output logic             ovf_sticky,
    output logic             adv_ovf
);

    logic         op_ok, special;
    logic [W-1:0] sp_quo, sp_rem, a_mag, b_mag;
    logic         quo_neg, rem_neg;
    logic         load, step, fixup, sp_fire;
    logic [W-1:0] q_mag, r_mag;
    logic         quo_neg_q, rem_neg_q;
    logic [W-1:0] fix_quo, fix_rem;

    sdiv_decode #(.W(W)) u_decode (
        .opcode  (opcode),
        .op_a    (dividend),
        .op_b    (divisor),
        .op_ok   (op_ok),
        .special (special),
        .sp_quo  (sp_quo),
        .sp_rem  (sp_rem),
        .a_mag   (a_mag),
        .b_mag   (b_mag),
        .quo_neg (quo_neg),
        .rem_neg (rem_neg)
    );

    sdiv_ctrl #(.W(W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .op_ok   (op_ok),
        .special (special),
        .busy    (busy),
        .load    (load),
        .step    (step),
        .fixup   (fixup),
        .sp_fire (sp_fire)
    );

    sdiv_core #(.W(W)) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .step  (step),
        .a_mag (a_mag),
        .b_mag (b_mag),
        .q_mag (q_mag),
        .r_mag (r_mag)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quo_neg_q <= 1'b0;
            rem_neg_q <= 1'b0;
        end else if (load) begin
            quo_neg_q <= quo_neg;
            rem_neg_q <= rem_neg;
        end
    end

    always_comb begin
        fix_quo = quo_neg_q ? (-q_mag) : q_mag;
        fix_rem = rem_neg_q ? (-r_mag) : r_mag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done       <= 1'b0;
            result     <= '0;
            ovf        <= 1'b0;
            ovf_sticky <= 1'b0;
            adv_ovf    <= 1'b0;
        end else if (sp_fire) begin
            done       <= 1'b1;
            result     <= {sp_rem, sp_quo};
            ovf        <= 1'b1;
            ovf_sticky <= 1'b1;
            adv_ovf    <= 1'b0;
        end else if (fixup) begin
            done       <= 1'b1;
            result     <= {fix_rem, fix_quo};
            ovf        <= 1'b0;
            adv_ovf    <= 1'b0;
        end else begin
            done       <= 1'b0;
        end
    end

endmodule

// File: rtl/sat_div_unit_checker.sv
module sat_div_unit_checker
    import sdiv_pkg::*;
#(
    parameter int W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [OPC_W-1:0] opcode,
    input logic             busy,
    input logic             done,
    input logic [2*W-1:0]   result,
    input logic             ovf,
    input logic             ovf_sticky,
    input logic             adv_ovf
);

    logic op_valid;
    assign op_valid = (opcode == OPC_DIV_SIGNED) || (opcode == OPC_DIV_UNSIGNED);

    a_r1_reject_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !op_valid) |=> (!busy && !done));

    a_r7_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(result) && $stable(ovf)));

    a_r8_sticky_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(ovf_sticky));

    a_r8_sticky_covers: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> ovf_sticky);

    a_r9_adv_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !adv_ovf);

    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r10_busy_ends_done: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));

endmodule

bind sat_div_unit sat_div_unit_checker #(.W(W)) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .opcode     (opcode),
    .busy       (busy),
    .done       (done),
    .result     (result),
    .ovf        (ovf),
    .ovf_sticky (ovf_sticky),
    .adv_ovf    (adv_ovf)
);

// File: tb/sat_div_unit_bench.sv
module sat_div_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [31:0] dividend = '0;
    logic [31:0] divisor = '0;
    logic        busy, done, ovf, ovf_sticky, adv_ovf;
    logic [63:0] result;

    always #4 clk = ~clk;

    sat_div_unit u_sat_div_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .opcode     (opcode),
        .dividend   (dividend),
        .divisor    (divisor),
        .busy       (busy),
        .done       (done),
        .result     (result),
        .ovf        (ovf),
        .ovf_sticky (ovf_sticky),
        .adv_ovf    (adv_ovf)
    );

    int nvec = 0;
    int nerr = 0;
    int cyc  = 0;
    bit finished = 1'b0;

    // behavioural model state
    int          m_cnt = 0;
    bit          m_done = 1'b0;
    logic [63:0] m_res = '0;
    bit          m_ovf = 1'b0;
    bit          m_sticky = 1'b0;
    logic [63:0] p_res = '0;
    string       p_tag = "R2";
    string       res_tag = "R12";
    string       hs_tag = "R10";

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    endtask

    function automatic void ref_div(input bit sgn, input logic [31:0] a, input logic [31:0] b,
                                    output logic [63:0] res, output bit ov, output string tag);
        longint sa, sb, q, r;
        if (sgn) begin
            if (b == 32'h0) begin
                res = {32'h0, (a[31] ? 32'h8000_0000 : 32'h7FFF_FFFF)};
                ov = 1'b1; tag = "R4";
            end else if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) begin
                res = {32'h0, 32'h7FFF_FFFF};
                ov = 1'b1; tag = "R5";
            end else begin
                sa = longint'($signed(a));
                sb = longint'($signed(b));
                q = sa / sb;
                r = sa % sb;
                res = {r[31:0], q[31:0]};
                ov = 1'b0; tag = "R3";
            end
        end else begin
            if (b == 32'h0) begin
                res = {32'h0, 32'hFFFF_FFFF};
                ov = 1'b1; tag = "R6";
            end else begin
                sa = longint'({32'h0, a});
                sb = longint'({32'h0, b});
                q = sa / sb;
                r = sa % sb;
                res = {r[31:0], q[31:0]};
                ov = 1'b0; tag = "R2";
            end
        end
    endfunction

    // reference model, advanced once per rising edge
    always @(posedge clk) begin
        bit          was_busy;
        bit          valid;
        logic [63:0] e_res;
        bit          e_ov;
        string       e_tag;
        cyc++;
        if (!rst_n) begin
            m_cnt = 0; m_done = 1'b0; m_res = '0; m_ovf = 1'b0; m_sticky = 1'b0;
            hs_tag = "R10"; res_tag = "R12";
        end else begin
            m_done   = 1'b0;
            hs_tag   = "R10";
            was_busy = (m_cnt > 0);
            valid    = (opcode == 8'h20) || (opcode == 8'h21);
            if (m_cnt > 0) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_done = 1'b1; m_res = p_res; m_ovf = 1'b0; res_tag = p_tag;
                end
            end
            if (start && was_busy) hs_tag = "R11";
            if (start && !was_busy && !valid) hs_tag = "R1";
            if (start && !was_busy && valid) begin
                ref_div(opcode == 8'h20, dividend, divisor, e_res, e_ov, e_tag);
                if (e_ov) begin
                    m_done = 1'b1; m_res = e_res; m_ovf = 1'b1; m_sticky = 1'b1; res_tag = e_tag;
                end else begin
                    m_cnt = 33; p_res = e_res; p_tag = e_tag;
                end
            end
        end
        if (cyc > 20000) begin
            nerr++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            report();
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk({63'h0, busy}, {63'h0, (m_cnt > 0)}, hs_tag);
            chk({63'h0, done}, {63'h0, m_done}, "R13");
            chk(result, m_res, res_tag);
            chk({63'h0, ovf}, {63'h0, m_ovf}, "R7");
            chk({63'h0, ovf_sticky}, {63'h0, m_sticky}, "R8");
            chk({63'h0, adv_ovf}, 64'h0, "R9");
        end
    end

    task automatic issue_now(input logic [7:0] op, input logic [31:0] a, input logic [31:0] b);
        opcode = op; dividend = a; divisor = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic issue(input logic [7:0] op, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        issue_now(op, a, b);
    endtask

    task automatic settle();
        repeat (36) @(negedge clk);
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!done);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R12: everything zero while reset is held
        chk({63'h0, busy}, 64'h0, "R12");
        chk({63'h0, done}, 64'h0, "R12");
        chk(result, 64'h0, "R12");
        chk({61'h0, ovf, ovf_sticky, adv_ovf}, 64'h0, "R12");
        rst_n = 1'b1;
        @(negedge clk);

        // R2 unsigned ordinary divisions
        issue(8'h21, 32'd100, 32'd7);           settle();
        issue(8'h21, 32'hFFFF_FFFF, 32'd1);     settle();
        issue(8'h21, 32'd5, 32'hFFFF_FFFF);     settle();
        issue(8'h21, 32'hDEAD_BEEF, 32'h0001_2345); settle();
        // R3 signed sign combinations
        issue(8'h20, -32'sd7, 32'sd2);          settle();
        issue(8'h20, 32'sd7, -32'sd2);          settle();
        issue(8'h20, -32'sd7, -32'sd2);         settle();
        issue(8'h20, 32'h8000_0000, 32'd1);     settle();
        issue(8'h20, 32'h8000_0000, 32'd2);     settle();
        // R4 signed divide by zero, R7 R8 flags
        issue(8'h20, 32'd5, 32'd0);             settle();
        issue(8'h20, 32'd0, 32'd0);             settle();
        issue(8'h20, -32'sd5, 32'd0);           settle();
        // R7 ovf cleared again, R8 sticky kept
        issue(8'h20, 32'd9, 32'd3);             settle();
        // R6 unsigned divide by zero
        issue(8'h21, 32'd42, 32'd0);            settle();
        // R5 signed overflow
        issue(8'h20, 32'h8000_0000, 32'hFFFF_FFFF); settle();
        // R1 rejected opcodes
        issue(8'h22, 32'd10, 32'd2);            settle();
        issue(8'h00, 32'd10, 32'd0);            settle();
        // R11 start while busy is ignored
        issue(8'h21, 32'd1000, 32'd10);
        repeat (5) @(negedge clk);
        issue_now(8'h20, 32'd6, 32'd0);
        repeat (10) @(negedge clk);
        issue_now(8'h21, 32'd77, 32'd7);
        settle();
        // R13 starts accepted in the done cycle
        issue(8'h20, -32'sd100, 32'sd9);
        wait_done();
        issue_now(8'h21, 32'd3, 32'd0);
        issue_now(8'h20, 32'sd100, -32'sd9);
        wait_done();
        issue_now(8'h21, 32'd50, 32'd5);
        settle();
        repeat (4) @(negedge clk);
        report();
    end

endmodule